// File: doc/BRIEF.md
# Multithreaded Thread-Select Controller

This block decides which hardware thread context feeds the next instruction into a shared in-order front end. It holds one program counter per thread. Each cycle it looks at a per-thread ready flag and a per-thread long-latency-miss flag, then presents the chosen thread number, that thread's PC and a fetch strobe. Selection and output are combinational from registered state, so a new thread can be chosen every cycle without a dead cycle.

There are two selection policies. In interleaved mode, issue rotates round-robin among eligible threads on every cycle. In switch-on-miss mode, one thread keeps issuing until it reports a long-latency miss. The block then requests a pipeline flush and holds fetch off for a configurable refill window before the new thread issues. A preferred thread can be named. It wins whenever it is eligible.

The policy settings are captured only while the pipeline reports idle. A thread's PC advances by a fixed step when that thread issues, or it is loaded from a redirect port.

Top module: `mt_thread_sel`

## Requirements
- R1: After reset the policy is interleaved with no preferred thread, the rotation pointer and the current thread are 0, thread t's PC is t*PC_STRIDE (default 0x100), fetch_valid_o and flush_o are low, and tid_o is 0.
- R2: In interleaved mode, the issued thread is the first eligible thread found by searching upward (with wrap) from the rotation pointer. After an issue of thread t the pointer becomes t+1 (mod thread count). flush_o is never raised in this mode.
- R3: A thread is eligible only when its bit of ready_i is 1 and its bit of miss_i is 0 (bit t belongs to thread t). fetch_valid_o is never high for an ineligible thread.
- R4: When no thread can issue, fetch_valid_o is low, tid_o shows the last current thread, and the rotation pointer keeps its value.
- R5: In switch-on-miss mode, the current thread issues whenever it is ready and has no miss. If it is not ready but has no miss, fetch_valid_o is low and no switch happens.
- R6: In switch-on-miss mode, a miss on the current thread selects the next eligible thread searching upward from current+1. In that cycle flush_o is 1, fetch_valid_o is 0 and tid_o/pc_o show the new thread. fetch_valid_o then stays low for REFILL_CYC further cycles (default 3) before the new thread can issue.
- R7: In switch-on-miss mode, a miss on the current thread with no other eligible thread raises neither flush_o nor fetch_valid_o, and the current thread is kept.
- R8: With the preference enabled, the preferred thread issues whenever it is eligible and the refill window is not running. In switch-on-miss mode, an eligible preferred thread that is not current forces a switch with the same flush and refill as R6.
- R9: Each issue advances the issuing thread's PC by PC_INC (default 4). pc_o always shows the PC of the thread on tid_o.
- R10: A redirect loads the named thread's PC with redir_pc_i at the clock edge, overriding the step of R9 for that thread. The value in pc_o during the redirect cycle is the old PC.
- R11: mode_i, pref_en_i and pref_id_i (mode 0 = interleaved, 1 = switch-on-miss) are captured only at a clock edge where pipe_idle_i is 1. At other times, changes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_idle_i | input | 1 | Pipeline idle; enables policy capture |
| mode_i | input | 1 | Policy: 0 interleaved, 1 switch-on-miss |
| pref_en_i | input | 1 | Enable preferred thread |
| pref_id_i | input | TID_W | Preferred thread number |
| ready_i | input | NUM_THREADS | Per-thread ready |
| miss_i | input | NUM_THREADS | Per-thread long-latency miss |
| redir_i | input | 1 | PC redirect strobe |
| redir_tid_i | input | TID_W | Thread to redirect |
| redir_pc_i | input | PC_W | Redirect target |
| tid_o | output | TID_W | Selected thread |
| pc_o | output | PC_W | PC of selected thread |
| fetch_valid_o | output | 1 | Fetch from tid_o/pc_o this cycle |
| flush_o | output | 1 | Pipeline flush request on a switch |

## Verification
The hardest state to reach is the refill window that follows a switch. To get there, the policy must first be captured in an idle cycle and the current thread must have been left on a known thread by earlier interleaved traffic. Then a miss must land on that thread while another thread is eligible. The bench reaches it through a fixed chain: a vector table of interleaved traffic sets the pointer and the PCs, an idle cycle loads switch-on-miss, and a miss on the current thread follows. Every cycle of the window is then counted out. After that, a preference is loaded in switch-on-miss mode to force a pre-emptive switch.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic {MODE_FINE = 1'b0, MODE_COARSE = 1'b1} mode_e;

  function automatic int wrap_add(int a, int b, int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction
endpackage

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] mask_i,
  input  logic [TID_W-1:0]       start_i,
  output logic                   found_o,
  output logic [TID_W-1:0]       idx_o
);
  import tsel_pkg::*;

  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (!found_o && mask_i[TID_W'(wrap_add(int'(start_i), i, NUM_THREADS))]) begin
        found_o = 1'b1;
        idx_o   = TID_W'(wrap_add(int'(start_i), i, NUM_THREADS));
      end
    end
  end

  // R3: a pick always lands on a masked-in thread
  always_comb begin
    if (found_o) p_pick_in_mask_r3: assert (mask_i[idx_o]);
  end
endmodule

// File: rtl/tsel_pc_bank.sv
module tsel_pc_bank #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = $clog2(NUM_THREADS),
  parameter int PC_W        = 32,
  parameter int PC_STRIDE   = 'h100,
  parameter int PC_INC      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [TID_W-1:0] adv_tid_i,
  input  logic             redir_i,
  input  logic [TID_W-1:0] redir_tid_i,
  input  logic [PC_W-1:0]  redir_pc_i,
  input  logic [TID_W-1:0] rd_tid_i,
  output logic [PC_W-1:0]  rd_pc_o
);
  logic [PC_W-1:0] pc_q [NUM_THREADS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_THREADS; t++) pc_q[t] <= PC_W'(t * PC_STRIDE);
    end else begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (redir_i && redir_tid_i == TID_W'(t))
          pc_q[t] <= redir_pc_i;
        else if (adv_i && adv_tid_i == TID_W'(t))
          pc_q[t] <= pc_q[t] + PC_W'(PC_INC);
      end
    end
  end

  assign rd_pc_o = pc_q[rd_tid_i];

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !(redir_i && redir_tid_i == adv_tid_i))
    |=> pc_q[$past(adv_tid_i)] == $past(pc_q[adv_tid_i]) + PC_W'(PC_INC));

  p_pc_redir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_i |=> pc_q[$past(redir_tid_i)] == $past(redir_pc_i));
endmodule

// File: rtl/tsel_refill_timer.sv
module tsel_refill_timer #(
  parameter int REFILL_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  if (REFILL_CYC > 0) begin : g_timer
    localparam int CNT_W = $clog2(REFILL_CYC + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (start_i)         cnt_q <= CNT_W'(REFILL_CYC);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    p_refill_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> busy_o);
    p_refill_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !start_i && cnt_q == CNT_W'(1)) |=> !busy_o);
  end else begin : g_none
    assign busy_o = 1'b0;
  end
endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = $clog2(NUM_THREADS),
  parameter int PC_W        = 32,
  parameter int PC_STRIDE   = 'h100,
  parameter int PC_INC      = 4,
  parameter int REFILL_CYC  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pipe_idle_i,
  input  logic                   mode_i,
  input  logic                   pref_en_i,
  input  logic [TID_W-1:0]       pref_id_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [NUM_THREADS-1:0] miss_i,
  input  logic                   redir_i,
  input  logic [TID_W-1:0]       redir_tid_i,
  input  logic [PC_W-1:0]        redir_pc_i,
  output logic [TID_W-1:0]       tid_o,
  output logic [PC_W-1:0]        pc_o,
  output logic                   fetch_valid_o,
  output logic                   flush_o
);
  import tsel_pkg::*;

  mode_e            mode_q;
  logic             pref_en_q;
  logic [TID_W-1:0] pref_id_q;
  logic [TID_W-1:0] ptr_q, cur_q, cur_nxt;
  logic [NUM_THREADS-1:0] elig;
  logic             fine_found, sw_found, busy, pref_ok, preempt;
  logic [TID_W-1:0] fine_idx, sw_idx, sel;
  logic             valid, flush;

  assign elig    = ready_i & ~miss_i;
  assign cur_nxt = TID_W'(wrap_add(int'(cur_q), 1, NUM_THREADS));
  assign pref_ok = pref_en_q && elig[pref_id_q];
  assign preempt = pref_ok && (pref_id_q != cur_q);

  // policy capture only while the pipe is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_FINE;
      pref_en_q <= 1'b0;
      pref_id_q <= '0;
    end else if (pipe_idle_i) begin
      mode_q    <= mode_e'(mode_i);
      pref_en_q <= pref_en_i;
      pref_id_q <= pref_id_i;
    end
  end

  tsel_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick_fine (
    .mask_i(elig), .start_i(ptr_q), .found_o(fine_found), .idx_o(fine_idx));

  tsel_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_pick_sw (
    .mask_i(elig), .start_i(cur_nxt), .found_o(sw_found), .idx_o(sw_idx));

  tsel_refill_timer #(.REFILL_CYC(REFILL_CYC)) u_refill (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(flush), .busy_o(busy));

  always_comb begin
    sel   = cur_q;
    valid = 1'b0;
    flush = 1'b0;
    if (busy) begin
      // refill window: hold off fetch
    end else if (mode_q == MODE_FINE) begin
      if (pref_ok) begin
        sel = pref_id_q; valid = 1'b1;
      end else if (fine_found) begin
        sel = fine_idx;  valid = 1'b1;
      end
    end else begin
      if (miss_i[cur_q] || preempt) begin
        if (pref_ok) begin
          sel = pref_id_q; flush = 1'b1;
        end else if (sw_found) begin
          sel = sw_idx;    flush = 1'b1;
        end
      end else if (ready_i[cur_q]) begin
        valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cur_q <= '0;
    end else if (valid) begin
      cur_q <= sel;
      ptr_q <= TID_W'(wrap_add(int'(sel), 1, NUM_THREADS));
    end else if (flush) begin
      cur_q <= sel;
    end
  end

  tsel_pc_bank #(
    .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .PC_W(PC_W),
    .PC_STRIDE(PC_STRIDE), .PC_INC(PC_INC)
  ) u_pcs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .adv_i(valid), .adv_tid_i(sel),
    .redir_i(redir_i), .redir_tid_i(redir_tid_i), .redir_pc_i(redir_pc_i),
    .rd_tid_i(sel), .rd_pc_o(pc_o));

  assign tid_o         = sel;
  assign fetch_valid_o = valid;
  assign flush_o       = flush;

  p_fetch_elig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> (ready_i[tid_o] && !miss_i[tid_o]));
  p_none_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> !fetch_valid_o);
  p_fine_no_flush_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FINE) |-> !flush_o);
  p_flush_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !fetch_valid_o);
  p_flush_refill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!fetch_valid_o && !flush_o));
  p_pref_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FINE && !busy && pref_ok) |-> (fetch_valid_o && tid_o == pref_id_q));
  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_idle_i |=> ($stable(mode_q) && $stable(pref_en_q) && $stable(pref_id_q)));
endmodule

// File: tb/mt_thread_sel_bench.sv
`timescale 1ns/1ps
module mt_thread_sel_bench;
  localparam int N = 3;
  localparam int TW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pipe_idle_i = 1'b0, mode_i = 1'b0, pref_en_i = 1'b0;
  logic [TW-1:0] pref_id_i = '0;
  logic [N-1:0] ready_i = '0, miss_i = '0;
  logic redir_i = 1'b0;
  logic [TW-1:0] redir_tid_i = '0;
  logic [31:0] redir_pc_i = '0;
  logic [TW-1:0] tid_o;
  logic [31:0] pc_o;
  logic fetch_valid_o, flush_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mt_thread_sel #(.NUM_THREADS(N), .REFILL_CYC(3)) u_mt_thread_sel (.*);

  // {ready, miss, valid, tid, pc}: interleaved traffic from reset
  localparam logic [40:0] VEC [10] = '{
    {3'b111, 3'b000, 1'b1, 2'd0, 32'h000},
    {3'b111, 3'b000, 1'b1, 2'd1, 32'h100},
    {3'b111, 3'b000, 1'b1, 2'd2, 32'h200},
    {3'b101, 3'b000, 1'b1, 2'd0, 32'h004},
    {3'b101, 3'b000, 1'b1, 2'd2, 32'h204},
    {3'b111, 3'b001, 1'b1, 2'd1, 32'h104},
    {3'b000, 3'b000, 1'b0, 2'd1, 32'h108},
    {3'b111, 3'b000, 1'b1, 2'd2, 32'h208},
    {3'b010, 3'b000, 1'b1, 2'd1, 32'h108},
    {3'b011, 3'b000, 1'b1, 2'd0, 32'h008}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] rdy, logic [N-1:0] ms);
    @(negedge clk_i);
    ready_i = rdy; miss_i = ms;
    redir_i = 1'b0; pipe_idle_i = 1'b0;
    #2;
  endtask

  task automatic expect_out(string req, logic v, logic f, logic [TW-1:0] t, logic [31:0] p);
    chk({req, " valid"}, 32'(fetch_valid_o), 32'(v));
    chk({req, " flush"}, 32'(flush_o), 32'(f));
    chk({req, " tid"}, 32'(tid_o), 32'(t));
    chk({req, " pc"}, pc_o, p);
  endtask

  initial begin
    repeat (3000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    expect_out("R1 reset", 1'b0, 1'b0, 2'd0, 32'h0);

    for (int i = 0; i < 10; i++) begin
      apply(VEC[i][40:38], VEC[i][37:35]);
      expect_out("R2/R3/R4 table", VEC[i][34], 1'b0, VEC[i][33:32], VEC[i][31:0]);
    end

    // R10 redirect: old PC shown, new one used next issue
    apply(3'b001, 3'b000);
    redir_i = 1'b1; redir_tid_i = 2'd0; redir_pc_i = 32'h40;
    expect_out("R10 redir cycle", 1'b1, 1'b0, 2'd0, 32'h00c);
    apply(3'b001, 3'b000);
    expect_out("R10 redir taken", 1'b1, 1'b0, 2'd0, 32'h040);
    apply(3'b000, 3'b000);
    redir_i = 1'b1; redir_tid_i = 2'd2; redir_pc_i = 32'h300;
    expect_out("R4 idle hold", 1'b0, 1'b0, 2'd0, 32'h044);
    apply(3'b100, 3'b000);
    expect_out("R10 redir idle thread", 1'b1, 1'b0, 2'd2, 32'h300);

    // R8 preferred thread in interleaved mode
    apply(3'b000, 3'b000);
    pipe_idle_i = 1'b1; mode_i = 1'b0; pref_en_i = 1'b1; pref_id_i = 2'd1;
    apply(3'b111, 3'b000);
    expect_out("R8 pref first", 1'b1, 1'b0, 2'd1, 32'h10c);
    apply(3'b111, 3'b000);
    expect_out("R8 pref again", 1'b1, 1'b0, 2'd1, 32'h110);
    apply(3'b101, 3'b000);
    expect_out("R8 pref stalled", 1'b1, 1'b0, 2'd2, 32'h304);
    pref_en_i = 1'b0;
    apply(3'b111, 3'b000);
    expect_out("R11 cfg ignored", 1'b1, 1'b0, 2'd1, 32'h114);

    // switch-on-miss
    apply(3'b000, 3'b000);
    pipe_idle_i = 1'b1; mode_i = 1'b1; pref_en_i = 1'b0;
    apply(3'b111, 3'b000);
    expect_out("R5 stay", 1'b1, 1'b0, 2'd1, 32'h118);
    apply(3'b101, 3'b000);
    expect_out("R5 short stall", 1'b0, 1'b0, 2'd1, 32'h11c);
    apply(3'b111, 3'b010);
    expect_out("R6 switch", 1'b0, 1'b1, 2'd2, 32'h308);
    for (int k = 0; k < 3; k++) begin
      apply(3'b111, 3'b000);
      expect_out("R6 refill", 1'b0, 1'b0, 2'd2, 32'h308);
    end
    apply(3'b111, 3'b000);
    expect_out("R6 resume", 1'b1, 1'b0, 2'd2, 32'h308);
    apply(3'b111, 3'b000);
    expect_out("R5 keep", 1'b1, 1'b0, 2'd2, 32'h30c);
    apply(3'b100, 3'b100);
    expect_out("R7 no target", 1'b0, 1'b0, 2'd2, 32'h310);

    // R8 preferred thread pre-empts in switch-on-miss mode
    apply(3'b000, 3'b000);
    pipe_idle_i = 1'b1; mode_i = 1'b1; pref_en_i = 1'b1; pref_id_i = 2'd0;
    apply(3'b111, 3'b000);
    expect_out("R8 pre-empt", 1'b0, 1'b1, 2'd0, 32'h044);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule